// File: doc/BRIEF.md
# Priority Interrupt Poll Arbiter

This block decides which of up to 32 device interfaces is granted an external interrupt. Each interface has a fixed priority number from 0 to 31, and a lower number means a higher priority. The arbiter keeps two bit vectors, each indexed by priority. The request vector records interfaces that are asking for service. The poll-continuity vector records interfaces that break the poll chain. An interface breaks the chain when it is requesting, or when its handler is still running after an acknowledge. Arbitration always looks at the lowest-numbered set bit of the poll-continuity vector. As a result, a running handler holds off every lower priority until a reset-interrupt command releases it, even after its own request bit has been cleared.

When polling is enabled, the arbiter selects one interface per clock and drives a poll strobe to it, together with its binary priority number. It then acts on the reply the interface returns in the same cycle:

- **Acknowledge:** the arbiter latches the device number and raises the external-interrupt flag to the CPU.
- **Cancel (poll-out):** the arbiter drops that interface's poll bit and moves on to the next request.
- **No reply (inhibit):** the interface blocks the chain without interrupting, and polling stops.

While the flag is up, no polling is done and the latched device number stays on the output until the CPU pulses the clear input.

The control is a three-state machine:

- **ST_IDLE** waits for an enable while at least one request is pending (transition *start*).
- **ST_POLL** evaluates one grant per cycle. It leaves on one of these transitions:
  - *ack* to ST_HOLD;
  - *cancel-continue*, staying in ST_POLL while requests remain;
  - *cancel-done*, *inhibit*, *no-grant* or *disabled*, each back to ST_IDLE.
- **ST_HOLD** keeps the flag set until *cpu-clear* returns to ST_IDLE.

Top module: `intr_poll_arbiter`

## Requirements
- R1: A pulse on `req_valid` with priority p sets bit p in both the request and poll-continuity vectors. A set in the same cycle as the clearing of that same bit wins, so the request survives.
- R2: In ST_POLL with `poll_en` high, the arbiter grants the lowest-numbered set poll bit, but only if that bit's request bit is also set. A grant drives `poll_valid` high for exactly that cycle, with `poll_sel` equal to the binary priority number.
- R3: When the lowest set poll bit has no request, no grant and no poll occur. All lower-priority requests stay pending with `extint` low.
- R4: A granted request bit is cleared at the end of the grant cycle, whatever the reply. A silently inhibited or cancelled priority is therefore not polled again without a new request.
- R5: If `reply_ack` is high in a grant cycle, `dev_addr` takes `reply_devno` and `extint` goes high on the next edge, and polling stops. Acknowledge wins over poll-out.
- R6: If `reply_pollout` is high without an acknowledge, `dev_addr` is cleared and the granted poll bit is cleared. If requests remain, polling continues with the next grant in the following cycle.
- R7: If the reply carries neither acknowledge nor poll-out, `dev_addr` is cleared, the poll bit stays set and polling stops. Lower priorities remain blocked.
- R8: While `extint` is high, `poll_valid` stays low and `dev_addr` holds its value. A pulse on `extint_clr` drops `extint` on the next edge.
- R9: A pulse on `rstint_valid` for priority p clears poll bit p only when request bit p is clear. If a second request is pending, the bit stays and p is polled again before any lower priority.
- R10: Reset (`rst_n` low) clears `dev_addr`, `extint` and both vectors.
- R11: No poll occurs while `poll_en` is low, and `busy` is high exactly while the machine is in ST_POLL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_en | input | 1 | CPU external interrupts enabled; polling allowed |
| req_valid | input | 1 | Interrupt request strobe from an interface |
| req_pri | input | 5 | Priority number of the requesting interface |
| rstint_valid | input | 1 | Reset-interrupt command strobe |
| rstint_pri | input | 5 | Priority number addressed by the reset-interrupt command |
| extint_clr | input | 1 | CPU clears the external-interrupt flag |
| reply_ack | input | 1 | Polled interface acknowledges (same cycle as poll) |
| reply_pollout | input | 1 | Polled interface passes the poll on (cancel) |
| reply_devno | input | 7 | Device number returned with an acknowledge |
| poll_valid | output | 1 | Poll strobe to the selected interface |
| poll_sel | output | 5 | Binary priority number of the polled interface |
| busy | output | 1 | Arbiter is in the polling state |
| extint | output | 1 | External-interrupt flag to the CPU |
| dev_addr | output | 7 | Registered device number of the acknowledged interface |

## Verification
Two functions can land in the same clock edge: a new request from an interface, and the clearing of that same priority's request bit as it is granted. The bench provokes this by enabling polling and pulsing a request for the granted priority during the exact cycle in which the poll strobe is out. The acknowledge then completes normally, but the request must survive. After the CPU clears the flag, the same priority must be polled and acknowledged a second time, which the scoreboard judges by expecting two consecutive polls of that number. A related overlap is a reset-interrupt command arriving while a second request for the same priority is pending. It is judged by which priority the next poll selects.

// File: rtl/intr_poll_pkg.sv
package intr_poll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_POLL = 2'd1,
        ST_HOLD = 2'd2
    } arb_state_t;

endpackage

// File: rtl/intr_pri_select.sv
// Finds the highest-priority chain break (lowest set poll bit), gates it with
// the request vector and binary-encodes the resulting one-hot grant.
module intr_pri_select #(
    parameter int NUM_PRI = 32,
    localparam int PRI_W  = $clog2(NUM_PRI)
) (
    input  logic [NUM_PRI-1:0] poll_vec,
    input  logic [NUM_PRI-1:0] req_vec,
    output logic [NUM_PRI-1:0] grant,
    output logic [PRI_W-1:0]   grant_idx,
    output logic               grant_any
);
    localparam logic [NUM_PRI-1:0] ONE = NUM_PRI'(1);

    logic [NUM_PRI-1:0] pri_mask;

    // isolate lowest set bit of the poll-continuity vector
    assign pri_mask  = poll_vec & (~poll_vec + ONE);
    assign grant     = pri_mask & req_vec;
    assign grant_any = |grant;

    always_comb begin
        grant_idx = '0;
        for (int i = 0; i < NUM_PRI; i++) begin
            if (grant[i]) begin
                grant_idx = grant_idx | PRI_W'(i);
            end
        end
    end

endmodule

// File: rtl/intr_vectors.sv
// Request and poll-continuity vectors. Sets win over same-cycle clears.
module intr_vectors #(
    parameter int NUM_PRI = 32,
    localparam int PRI_W  = $clog2(NUM_PRI)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_valid,
    input  logic [PRI_W-1:0]   set_idx,
    input  logic               rstint_valid,
    input  logic [PRI_W-1:0]   rstint_idx,
    input  logic [NUM_PRI-1:0] clr_req,
    input  logic [NUM_PRI-1:0] clr_poll,
    output logic [NUM_PRI-1:0] req_vec,
    output logic [NUM_PRI-1:0] poll_vec
);
    localparam logic [NUM_PRI-1:0] ONE = NUM_PRI'(1);

    logic [NUM_PRI-1:0] set_m;
    logic [NUM_PRI-1:0] rstint_m;

    always_comb begin
        set_m    = set_valid ? (ONE << set_idx) : '0;
        // a reset-interrupt only releases the chain when no request is pending
        rstint_m = rstint_valid ? ((ONE << rstint_idx) & ~req_vec) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_vec  <= '0;
            poll_vec <= '0;
        end else begin
            req_vec  <= (req_vec & ~clr_req) | set_m;
            poll_vec <= (poll_vec & ~(clr_poll | rstint_m)) | set_m;
        end
    end

endmodule

// File: rtl/intr_poll_arbiter.sv
module intr_poll_arbiter #(
    parameter int NUM_PRI  = 32,
    parameter int DEVNO_W  = 7,
    localparam int PRI_W   = $clog2(NUM_PRI)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               poll_en,
    input  logic               req_valid,
    input  logic [PRI_W-1:0]   req_pri,
    input  logic               rstint_valid,
    input  logic [PRI_W-1:0]   rstint_pri,
    input  logic               extint_clr,
    input  logic               reply_ack,
    input  logic               reply_pollout,
    input  logic [DEVNO_W-1:0] reply_devno,
    output logic               poll_valid,
    output logic [PRI_W-1:0]   poll_sel,
    output logic               busy,
    output logic               extint,
    output logic [DEVNO_W-1:0] dev_addr
);
    import intr_poll_pkg::*;

    arb_state_t         state_q, state_d;
    logic [NUM_PRI-1:0] req_vec, poll_vec, grant;
    logic [NUM_PRI-1:0] clr_req, clr_poll;
    logic [PRI_W-1:0]   grant_idx;
    logic               grant_any;
    logic               poll_go;
    logic               is_cancel;

    intr_vectors #(.NUM_PRI(NUM_PRI)) u_vec (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_valid    (req_valid),
        .set_idx      (req_pri),
        .rstint_valid (rstint_valid),
        .rstint_idx   (rstint_pri),
        .clr_req      (clr_req),
        .clr_poll     (clr_poll),
        .req_vec      (req_vec),
        .poll_vec     (poll_vec)
    );

    intr_pri_select #(.NUM_PRI(NUM_PRI)) u_sel (
        .poll_vec  (poll_vec),
        .req_vec   (req_vec),
        .grant     (grant),
        .grant_idx (grant_idx),
        .grant_any (grant_any)
    );

    assign poll_go   = (state_q == ST_POLL) && poll_en && grant_any;
    assign is_cancel = reply_pollout && !reply_ack;
    assign clr_req   = poll_go ? grant : '0;
    assign clr_poll  = (poll_go && is_cancel) ? grant : '0;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (poll_en && (|req_vec)) state_d = ST_POLL;         // start
            end
            ST_POLL: begin
                if (!poll_en)               state_d = ST_IDLE;        // disabled
                else if (!grant_any)        state_d = ST_IDLE;        // no-grant
                else if (reply_ack)         state_d = ST_HOLD;        // ack
                else if (reply_pollout)
                    state_d = (|(req_vec & ~grant)) ? ST_POLL         // cancel-continue
                                                    : ST_IDLE;        // cancel-done
                else                        state_d = ST_IDLE;        // inhibit
            end
            ST_HOLD: begin
                if (extint_clr)             state_d = ST_IDLE;        // cpu-clear
            end
            default:                        state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            extint   <= 1'b0;
            dev_addr <= '0;
        end else begin
            if (poll_go) begin
                if (reply_ack) begin
                    dev_addr <= reply_devno;
                    extint   <= 1'b1;
                end else begin
                    dev_addr <= '0;
                end
            end else if ((state_q == ST_HOLD) && extint_clr) begin
                extint <= 1'b0;
            end
        end
    end

    assign poll_valid = poll_go;
    assign poll_sel   = grant_idx;
    assign busy       = (state_q == ST_POLL);

endmodule

// File: rtl/intr_poll_arbiter_chk.sv
module intr_poll_arbiter_chk #(
    parameter int DEVNO_W = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               poll_en,
    input logic               extint_clr,
    input logic               reply_ack,
    input logic               reply_pollout,
    input logic [DEVNO_W-1:0] reply_devno,
    input logic               poll_valid,
    input logic               extint,
    input logic [DEVNO_W-1:0] dev_addr
);
    // R8
    no_poll_while_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        extint |-> !poll_valid);

    // R5
    ack_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_valid && reply_ack) |=> (extint && dev_addr == $past(reply_devno)));

    // R6
    cancel_clears_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_valid && reply_pollout && !reply_ack) |=> (dev_addr == '0 && !extint));

    // R7
    inhibit_clears_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_valid && !reply_pollout && !reply_ack) |=> (dev_addr == '0 && !extint));

    // R8
    flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (extint && !extint_clr) |=> (extint && $stable(dev_addr)));

    // R11
    poll_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_valid |-> poll_en);
endmodule

bind intr_poll_arbiter intr_poll_arbiter_chk #(.DEVNO_W(DEVNO_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .poll_en       (poll_en),
    .extint_clr    (extint_clr),
    .reply_ack     (reply_ack),
    .reply_pollout (reply_pollout),
    .reply_devno   (reply_devno),
    .poll_valid    (poll_valid),
    .extint        (extint),
    .dev_addr      (dev_addr)
);

// File: tb/intr_poll_arbiter_tb.sv
module intr_poll_arbiter_tb;
    localparam int BEH_ACK = 0, BEH_CANCEL = 1, BEH_SILENT = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       poll_en = 1'b0;
    logic       req_valid = 1'b0;
    logic [4:0] req_pri = '0;
    logic       rstint_valid = 1'b0;
    logic [4:0] rstint_pri = '0;
    logic       extint_clr = 1'b0;
    logic       reply_ack, reply_pollout;
    logic [6:0] reply_devno;
    logic       poll_valid, busy, extint;
    logic [4:0] poll_sel;
    logic [6:0] dev_addr;

    int beh [32];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int exp_q [$];

    always #2 clk = ~clk;   // 250 MHz

    intr_poll_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .poll_en(poll_en),
        .req_valid(req_valid), .req_pri(req_pri),
        .rstint_valid(rstint_valid), .rstint_pri(rstint_pri),
        .extint_clr(extint_clr),
        .reply_ack(reply_ack), .reply_pollout(reply_pollout), .reply_devno(reply_devno),
        .poll_valid(poll_valid), .poll_sel(poll_sel), .busy(busy),
        .extint(extint), .dev_addr(dev_addr)
    );

    function automatic logic [6:0] devno_of(input int p);
        return 7'(p) ^ 7'h55;
    endfunction

    // interface model: replies in the poll cycle
    always_comb begin
        reply_ack     = poll_valid && (beh[poll_sel] == BEH_ACK);
        reply_pollout = poll_valid && (beh[poll_sel] == BEH_CANCEL);
        reply_devno   = devno_of(int'(poll_sel));
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: every poll must match the next expected priority
    always @(negedge clk) begin
        if (rst_n && poll_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected poll actual=%0d expected=none", poll_sel);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (int'(poll_sel) != e) begin
                    errors++;
                    $display("FAIL R2 poll_sel actual=%0d expected=%0d", poll_sel, e);
                end
            end
        end
    end

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_req(input int p);
        @(negedge clk); req_valid = 1'b1; req_pri = 5'(p);
        @(negedge clk); req_valid = 1'b0;
    endtask

    task automatic do_rstint(input int p);
        @(negedge clk); rstint_valid = 1'b1; rstint_pri = 5'(p);
        @(negedge clk); rstint_valid = 1'b0;
    endtask

    task automatic do_clr();
        @(negedge clk); extint_clr = 1'b1;
        @(negedge clk); extint_clr = 1'b0;
    endtask

    task automatic wait_ack(input int p, input string tag);
        int n = 0;
        while (!extint && n < 60) begin
            @(negedge clk);
            n++;
        end
        check(extint == 1'b1, {tag, " extint"}, int'(extint), 1);
        check(dev_addr == devno_of(p), {tag, " dev_addr"}, int'(dev_addr), int'(devno_of(p)));
    endtask

    initial begin
        for (int i = 0; i < 32; i++) beh[i] = BEH_ACK;
        settle(3);
        // R10 reset state
        check(extint == 1'b0 && dev_addr == '0 && busy == 1'b0, "R10 reset state",
              {extint, dev_addr}, 0);
        @(negedge clk); rst_n = 1'b1;
        poll_en = 1'b1;

        // R1 R2 R5 basic acknowledge
        exp_q.push_back(6);
        do_req(6);
        wait_ack(6, "R5");
        // R8 no poll while flag set
        do_req(3);
        settle(6);
        check(dev_addr == devno_of(6) && extint, "R8 held", int'(dev_addr), int'(devno_of(6)));
        exp_q.push_back(3);
        do_clr();
        wait_ack(3, "R8 after clear");
        do_clr();
        // R3 blocked by active handlers at 3 and 6
        do_req(9);
        settle(6);
        check(extint == 1'b0, "R3 blocked by 3", int'(extint), 0);
        do_rstint(3);
        settle(6);
        check(extint == 1'b0, "R3 blocked by 6", int'(extint), 0);
        exp_q.push_back(9);
        do_rstint(6);
        wait_ack(9, "R9 release");
        do_clr();
        do_rstint(9);

        // R6 cancel then continue; R11 no poll while disabled
        poll_en = 1'b0;
        beh[4] = BEH_CANCEL;
        do_req(4);
        do_req(10);
        settle(4);
        check(busy == 1'b0 && extint == 1'b0, "R11 disabled", int'(busy), 0);
        exp_q.push_back(4);
        exp_q.push_back(10);
        @(negedge clk); poll_en = 1'b1;
        wait_ack(10, "R6 continue");
        do_clr();
        do_rstint(10);
        exp_q.push_back(12);      // poll bit 4 was dropped, 12 not blocked
        do_req(12);
        wait_ack(12, "R6 bit cleared");
        do_clr();
        do_rstint(12);

        // R7 inhibit: address cleared, chain stays blocked; R4 request dropped
        poll_en = 1'b0;
        beh[2] = BEH_SILENT;
        do_req(2);
        do_req(5);
        exp_q.push_back(2);
        @(negedge clk); poll_en = 1'b1;
        settle(4);
        check(dev_addr == '0, "R7 addr cleared", int'(dev_addr), 0);
        settle(8);
        check(extint == 1'b0, "R7 lower blocked", int'(extint), 0);
        exp_q.push_back(5);
        do_rstint(2);             // R4: request bit 2 already clear, so release works
        wait_ack(5, "R4 release after inhibit");
        do_clr();
        do_rstint(5);

        // R9 second request while handler active
        exp_q.push_back(7);
        do_req(7);
        wait_ack(7, "R9 first");
        poll_en = 1'b0;
        do_clr();
        do_req(7);
        do_rstint(7);             // request pending: poll bit must stay
        do_req(20);
        exp_q.push_back(7);
        @(negedge clk); poll_en = 1'b1;
        wait_ack(7, "R9 second");
        do_clr();
        exp_q.push_back(20);
        do_rstint(7);
        wait_ack(20, "R9 then lower");
        do_clr();
        do_rstint(20);

        // R1 request collides with its own grant clear
        poll_en = 1'b0;
        do_req(15);
        exp_q.push_back(15);
        exp_q.push_back(15);
        @(negedge clk); poll_en = 1'b1;
        @(posedge clk);
        @(negedge clk); req_valid = 1'b1; req_pri = 5'd15;
        @(negedge clk); req_valid = 1'b0;
        wait_ack(15, "R1 collide first");
        do_clr();
        wait_ack(15, "R1 collide second");
        do_clr();
        do_rstint(15);

        // R10 reset mid-interrupt clears flag, address and vectors
        exp_q.push_back(8);
        do_req(8);
        wait_ack(8, "R10 pre");
        @(negedge clk); rst_n = 1'b0;
        settle(2);
        check(extint == 1'b0 && dev_addr == '0, "R10 reset clears", {extint, dev_addr}, 0);
        @(negedge clk); rst_n = 1'b1;
        exp_q.push_back(11);
        do_req(11);
        wait_ack(11, "R10 vectors cleared");
        do_clr();
        settle(4);
        check(exp_q.size() == 0, "R2 all polls seen", exp_q.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule